// File: doc/BRIEF.md
# Transmit/Receive Frame Buffer with Watermarks and DMA Requests

This block sits between a register-bus front end and a serial shift engine. It buffers outgoing frames in a transmit queue and incoming frames in a receive queue, each holding up to `DEPTH` frames of up to 16 bits. The bus side pushes transmit frames and pops receive frames, reads both occupancy counts, and sees full and empty flags plus one-cycle error pulses for dropped or missing frames. The engine side drains the transmit queue and fills the receive queue through valid/ready streams.

Four threshold registers set the service points. Two of them drive interrupt conditions and two drive DMA request levels, one pair per direction. A threshold write is accepted only when the value is below the physical depth, so software can find the depth by writing rising values and reading each one back. A two-bit enable word gates the two DMA requests.

Top module: `xfer_fifo_pair`

## Requirements
- R1: During and after reset, both levels are 0, both empty flags are 1, both full flags are 0, all four thresholds are 0, the error pulses are 0 and both DMA requests are 0.
- R2: Transmit frames leave on `eng_tx_data` in push order. `eng_tx_valid` is high while `tx_level` is non-zero, a frame is removed on a cycle with `eng_tx_valid` and `eng_tx_ready`, and `eng_tx_data` is 0 while the queue is empty.
- R3: A push to a full transmit queue is dropped even if a frame leaves in the same cycle, and `tx_ovf` is high for exactly the following cycle.
- R4: Receive frames are taken on cycles where `eng_rx_valid` and `eng_rx_ready` are both high. The bus reads them in arrival order on `rx_pop_data`, which shows the oldest frame, and `rx_pop` removes that frame.
- R5: `eng_rx_ready` is low while the receive queue is full. A frame offered then is dropped, and `rx_ovf` is high for exactly the following cycle.
- R6: A pop from an empty receive queue leaves the level at 0, `rx_pop_data` reads 0, and `rx_unf` is high for exactly the following cycle.
- R7: `cfg_sel` selects the threshold: 0 is the transmit interrupt threshold, 1 the receive interrupt threshold, 2 the transmit DMA watermark and 3 the receive DMA watermark. A write with `cfg_wdata` below `DEPTH` is visible on the next cycle. A write at or above `DEPTH` leaves the register unchanged.
- R8: Each full flag is high exactly when its level equals `DEPTH`, and each empty flag is high exactly when its level is 0.
- R9: `irq_tx_low` is high while `tx_level` is at or below the transmit interrupt threshold. `irq_rx_high` is high while `rx_level` is above the receive interrupt threshold.
- R10: `dma_en` bit 1 enables the transmit request and bit 0 the receive request. `dma_tx_req` is high while bit 1 is set and `tx_level` is at or below the transmit DMA watermark. `dma_rx_req` is high while bit 0 is set and `rx_level` is above the receive DMA watermark.
- R11: When a push and a removal hit the same non-full queue in one cycle, the level is unchanged and frame order is kept.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tx_push | input | 1 | Bus push strobe into the transmit queue |
| tx_push_data | input | DATA_W | Frame to push |
| rx_pop | input | 1 | Bus pop strobe from the receive queue |
| rx_pop_data | output | DATA_W | Oldest receive frame, 0 when empty |
| cfg_we | input | 1 | Threshold write strobe |
| cfg_sel | input | 2 | Threshold select (see R7) |
| cfg_wdata | input | TH_W | Threshold write value |
| tx_irq_th | output | TH_W | Transmit interrupt threshold readback |
| rx_irq_th | output | TH_W | Receive interrupt threshold readback |
| tx_dma_th | output | TH_W | Transmit DMA watermark readback |
| rx_dma_th | output | TH_W | Receive DMA watermark readback |
| dma_en | input | 2 | DMA enables: bit 1 transmit, bit 0 receive |
| tx_level | output | clog2(DEPTH+1) | Transmit occupancy |
| rx_level | output | clog2(DEPTH+1) | Receive occupancy |
| tx_full | output | 1 | Transmit queue full |
| tx_empty | output | 1 | Transmit queue empty |
| rx_full | output | 1 | Receive queue full |
| rx_empty | output | 1 | Receive queue empty |
| tx_ovf | output | 1 | Transmit push dropped (one-cycle pulse) |
| rx_ovf | output | 1 | Receive frame dropped (one-cycle pulse) |
| rx_unf | output | 1 | Pop from empty receive queue (one-cycle pulse) |
| irq_tx_low | output | 1 | Transmit level at or below its interrupt threshold |
| irq_rx_high | output | 1 | Receive level above its interrupt threshold |
| dma_tx_req | output | 1 | Transmit DMA request |
| dma_rx_req | output | 1 | Receive DMA request |
| eng_tx_valid | output | 1 | Transmit frame available to the engine |
| eng_tx_data | output | DATA_W | Transmit frame to the engine |
| eng_tx_ready | input | 1 | Engine accepts the transmit frame |
| eng_rx_valid | input | 1 | Engine offers a receive frame |
| eng_rx_data | input | DATA_W | Receive frame from the engine |
| eng_rx_ready | output | 1 | Receive queue can take a frame |

## Verification
The bench targets pushes into a full transmit queue in the same cycle as an engine removal. A design that let that push through would read one level too high and emit a frame that should have been lost. It also targets a pop from an empty receive queue while a frame is arriving in the same cycle, where a careless design would hand out stale data or miss the underflow pulse. Threshold writes of exactly `DEPTH` and of the largest encodable value are checked, because an off-by-one in the acceptance test would break depth discovery. The bench also checks the strict comparison on the receive side against the inclusive one on the transmit side, where mixing the two moves every request by one frame.

// File: rtl/fifo_pair_pkg.sv
package fifo_pair_pkg;

    typedef enum logic [1:0] {
        SEL_TX_IRQ = 2'd0,
        SEL_RX_IRQ = 2'd1,
        SEL_TX_DMA = 2'd2,
        SEL_RX_DMA = 2'd3
    } th_sel_e;

    localparam int DMA_RX_BIT = 0;
    localparam int DMA_TX_BIT = 1;
    localparam int NUM_TH     = 4;

    typedef struct packed {
        logic full;
        logic empty;
    } fifo_flags_t;

    // a threshold is kept only if it can actually be reached by the level
    function automatic logic below_depth(input int value, input int depth);
        return value < depth;
    endfunction

endpackage

// File: rtl/frame_fifo.sv
module frame_fifo
    import fifo_pair_pkg::*;
#(
    parameter int DATA_W = 16,
    parameter int DEPTH  = 16
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic                       wr_en,
    input  logic [DATA_W-1:0]          wr_data,
    input  logic                       rd_en,
    output logic [DATA_W-1:0]          rd_data,
    output logic [$clog2(DEPTH+1)-1:0] level,
    output fifo_flags_t                flags
);
    localparam int PTR_W = $clog2(DEPTH);
    localparam int LVL_W = $clog2(DEPTH+1);

    logic [DATA_W-1:0] mem [DEPTH];
    logic [PTR_W-1:0]  wr_ptr, rd_ptr;
    logic [LVL_W-1:0]  count;
    logic              do_wr, do_rd;

    assign flags.full  = (count == LVL_W'(DEPTH));
    assign flags.empty = (count == '0);
    assign do_wr = wr_en && !flags.full;
    assign do_rd = rd_en && !flags.empty;

    function automatic logic [PTR_W-1:0] bump(input logic [PTR_W-1:0] p);
        return (p == PTR_W'(DEPTH-1)) ? '0 : p + PTR_W'(1);
    endfunction

    always_ff @(posedge clk) begin
        if (rst) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else begin
            if (do_wr) wr_ptr <= bump(wr_ptr);
            if (do_rd) rd_ptr <= bump(rd_ptr);
            unique case ({do_wr, do_rd})
                2'b10:   count <= count + LVL_W'(1);
                2'b01:   count <= count - LVL_W'(1);
                default: count <= count;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (do_wr) mem[wr_ptr] <= wr_data;
    end

    assign rd_data = flags.empty ? '0 : mem[rd_ptr];
    assign level   = count;

endmodule

// File: rtl/thresh_reg.sv
module thresh_reg
    import fifo_pair_pkg::*;
#(
    parameter int TH_W  = 5,
    parameter int DEPTH = 16
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            we,
    input  logic [TH_W-1:0] wdata,
    output logic [TH_W-1:0] q
);
    always_ff @(posedge clk) begin
        if (rst)
            q <= '0;
        else if (we && below_depth(int'(wdata), DEPTH))
            q <= wdata;
    end
endmodule

// File: rtl/xfer_fifo_pair.sv
module xfer_fifo_pair
    import fifo_pair_pkg::*;
#(
    parameter int DATA_W = 16,
    parameter int DEPTH  = 16,
    parameter int TH_W   = 5
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic                       tx_push,
    input  logic [DATA_W-1:0]          tx_push_data,
    input  logic                       rx_pop,
    output logic [DATA_W-1:0]          rx_pop_data,
    input  logic                       cfg_we,
    input  logic [1:0]                 cfg_sel,
    input  logic [TH_W-1:0]            cfg_wdata,
    output logic [TH_W-1:0]            tx_irq_th,
    output logic [TH_W-1:0]            rx_irq_th,
    output logic [TH_W-1:0]            tx_dma_th,
    output logic [TH_W-1:0]            rx_dma_th,
    input  logic [1:0]                 dma_en,
    output logic [$clog2(DEPTH+1)-1:0] tx_level,
    output logic [$clog2(DEPTH+1)-1:0] rx_level,
    output logic                       tx_full,
    output logic                       tx_empty,
    output logic                       rx_full,
    output logic                       rx_empty,
    output logic                       tx_ovf,
    output logic                       rx_ovf,
    output logic                       rx_unf,
    output logic                       irq_tx_low,
    output logic                       irq_rx_high,
    output logic                       dma_tx_req,
    output logic                       dma_rx_req,
    output logic                       eng_tx_valid,
    output logic [DATA_W-1:0]          eng_tx_data,
    input  logic                       eng_tx_ready,
    input  logic                       eng_rx_valid,
    input  logic [DATA_W-1:0]          eng_rx_data,
    output logic                       eng_rx_ready
);
    fifo_flags_t     tx_fl, rx_fl;
    logic [TH_W-1:0] th_q [NUM_TH];
    logic [TH_W-1:0] tx_lvl_x, rx_lvl_x;

    frame_fifo #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_txq (
        .clk(clk), .rst(rst),
        .wr_en(tx_push), .wr_data(tx_push_data),
        .rd_en(eng_tx_ready), .rd_data(eng_tx_data),
        .level(tx_level), .flags(tx_fl)
    );

    frame_fifo #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_rxq (
        .clk(clk), .rst(rst),
        .wr_en(eng_rx_valid), .wr_data(eng_rx_data),
        .rd_en(rx_pop), .rd_data(rx_pop_data),
        .level(rx_level), .flags(rx_fl)
    );

    for (genvar g = 0; g < NUM_TH; g++) begin : g_th
        thresh_reg #(.TH_W(TH_W), .DEPTH(DEPTH)) u_th (
            .clk(clk), .rst(rst),
            .we(cfg_we && (cfg_sel == 2'(g))),
            .wdata(cfg_wdata),
            .q(th_q[g])
        );
    end

    assign tx_irq_th = th_q[SEL_TX_IRQ];
    assign rx_irq_th = th_q[SEL_RX_IRQ];
    assign tx_dma_th = th_q[SEL_TX_DMA];
    assign rx_dma_th = th_q[SEL_RX_DMA];

    assign tx_full      = tx_fl.full;
    assign tx_empty     = tx_fl.empty;
    assign rx_full      = rx_fl.full;
    assign rx_empty     = rx_fl.empty;
    assign eng_tx_valid = !tx_fl.empty;
    assign eng_rx_ready = !rx_fl.full;

    always_ff @(posedge clk) begin
        if (rst) begin
            tx_ovf <= 1'b0;
            rx_ovf <= 1'b0;
            rx_unf <= 1'b0;
        end else begin
            tx_ovf <= tx_push && tx_fl.full;
            rx_ovf <= eng_rx_valid && rx_fl.full;
            rx_unf <= rx_pop && rx_fl.empty;
        end
    end

    // levels widened to threshold width (DEPTH < 2**TH_W)
    assign tx_lvl_x = TH_W'(tx_level);
    assign rx_lvl_x = TH_W'(rx_level);

    assign irq_tx_low  = tx_lvl_x <= tx_irq_th;
    assign irq_rx_high = rx_lvl_x >  rx_irq_th;
    assign dma_tx_req  = dma_en[DMA_TX_BIT] && (tx_lvl_x <= tx_dma_th);
    assign dma_rx_req  = dma_en[DMA_RX_BIT] && (rx_lvl_x >  rx_dma_th);

endmodule

// File: rtl/fifo_pair_chk.sv
module fifo_pair_chk #(
    parameter int DEPTH = 16,
    parameter int TH_W  = 5
) (
    input logic                       clk,
    input logic                       rst,
    input logic                       tx_push,
    input logic                       rx_pop,
    input logic                       cfg_we,
    input logic [1:0]                 cfg_sel,
    input logic [TH_W-1:0]            cfg_wdata,
    input logic [TH_W-1:0]            tx_irq_th,
    input logic [$clog2(DEPTH+1)-1:0] tx_level,
    input logic [$clog2(DEPTH+1)-1:0] rx_level,
    input logic                       tx_full,
    input logic                       tx_empty,
    input logic                       rx_full,
    input logic                       rx_empty,
    input logic                       tx_ovf,
    input logic                       rx_ovf,
    input logic                       rx_unf,
    input logic                       dma_rx_req,
    input logic                       eng_tx_valid,
    input logic                       eng_tx_ready,
    input logic                       eng_rx_valid
);
    assert_tx_ovf_cause_R3: assert property (@(posedge clk) disable iff (rst)
        tx_ovf |-> ($past(tx_push) && $past(tx_full)));

    assert_rx_ovf_cause_R5: assert property (@(posedge clk) disable iff (rst)
        rx_ovf |-> ($past(eng_rx_valid) && $past(rx_full)));

    assert_rx_unf_cause_R6: assert property (@(posedge clk) disable iff (rst)
        rx_unf |-> ($past(rx_pop) && $past(rx_empty)));

    assert_flags_exclusive_R8: assert property (@(posedge clk) disable iff (rst)
        !(tx_full && tx_empty) && !(rx_full && rx_empty));

    assert_level_bound_R8: assert property (@(posedge clk) disable iff (rst)
        (int'(tx_level) <= DEPTH) && (int'(rx_level) <= DEPTH));

    assert_th_ignored_R7: assert property (@(posedge clk) disable iff (rst)
        (cfg_we && cfg_sel == 2'd0 && int'(cfg_wdata) >= DEPTH) |=> $stable(tx_irq_th));

    assert_th_below_depth_R7: assert property (@(posedge clk) disable iff (rst)
        int'(tx_irq_th) < DEPTH);

    assert_push_grows_R2: assert property (@(posedge clk) disable iff (rst)
        (tx_push && !tx_full && !(eng_tx_valid && eng_tx_ready))
        |=> int'(tx_level) == int'($past(tx_level)) + 1);

    assert_same_cycle_level_R11: assert property (@(posedge clk) disable iff (rst)
        (tx_push && !tx_full && eng_tx_valid && eng_tx_ready) |=> $stable(tx_level));

    assert_rx_dma_nonempty_R10: assert property (@(posedge clk) disable iff (rst)
        dma_rx_req |-> !rx_empty);

endmodule

bind xfer_fifo_pair fifo_pair_chk #(.DEPTH(DEPTH), .TH_W(TH_W)) u_chk (.*);

// File: tb/sim_xfer_fifo_pair.sv
module sim_xfer_fifo_pair;
    localparam int CLK_PERIOD = 10;
    localparam int DATA_W = 16;
    localparam int DEPTH  = 16;
    localparam int TH_W   = 5;
    localparam int LVL_W  = $clog2(DEPTH+1);

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic tx_push = 0, rx_pop = 0, cfg_we = 0, eng_tx_ready = 0, eng_rx_valid = 0;
    logic [DATA_W-1:0] tx_push_data = '0, eng_rx_data = '0;
    logic [1:0] cfg_sel = '0, dma_en = '0;
    logic [TH_W-1:0] cfg_wdata = '0;
    logic [DATA_W-1:0] rx_pop_data, eng_tx_data;
    logic [TH_W-1:0] tx_irq_th, rx_irq_th, tx_dma_th, rx_dma_th;
    logic [LVL_W-1:0] tx_level, rx_level;
    logic tx_full, tx_empty, rx_full, rx_empty, tx_ovf, rx_ovf, rx_unf;
    logic irq_tx_low, irq_rx_high, dma_tx_req, dma_rx_req, eng_tx_valid, eng_rx_ready;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    xfer_fifo_pair #(.DATA_W(DATA_W), .DEPTH(DEPTH), .TH_W(TH_W)) u0 (
        .clk(clk), .rst(rst), .tx_push(tx_push), .tx_push_data(tx_push_data),
        .rx_pop(rx_pop), .rx_pop_data(rx_pop_data), .cfg_we(cfg_we),
        .cfg_sel(cfg_sel), .cfg_wdata(cfg_wdata), .tx_irq_th(tx_irq_th),
        .rx_irq_th(rx_irq_th), .tx_dma_th(tx_dma_th), .rx_dma_th(rx_dma_th),
        .dma_en(dma_en), .tx_level(tx_level), .rx_level(rx_level),
        .tx_full(tx_full), .tx_empty(tx_empty), .rx_full(rx_full), .rx_empty(rx_empty),
        .tx_ovf(tx_ovf), .rx_ovf(rx_ovf), .rx_unf(rx_unf),
        .irq_tx_low(irq_tx_low), .irq_rx_high(irq_rx_high),
        .dma_tx_req(dma_tx_req), .dma_rx_req(dma_rx_req),
        .eng_tx_valid(eng_tx_valid), .eng_tx_data(eng_tx_data), .eng_tx_ready(eng_tx_ready),
        .eng_rx_valid(eng_rx_valid), .eng_rx_data(eng_rx_data), .eng_rx_ready(eng_rx_ready)
    );

    // behavioural reference model
    logic [DATA_W-1:0] mtx[$];
    logic [DATA_W-1:0] mrx[$];
    int  mth[4];
    bit  m_tx_ovf, m_rx_ovf, m_rx_unf;

    always @(posedge clk) begin
        if (rst) begin
            mtx.delete(); mrx.delete();
            foreach (mth[i]) mth[i] = 0;
            m_tx_ovf = 0; m_rx_ovf = 0; m_rx_unf = 0;
        end else begin
            bit tpop, tpush, rpop, rpush;
            tpop  = eng_tx_ready && mtx.size() != 0;
            tpush = tx_push && mtx.size() != DEPTH;
            rpop  = rx_pop && mrx.size() != 0;
            rpush = eng_rx_valid && mrx.size() != DEPTH;
            m_tx_ovf = tx_push && mtx.size() == DEPTH;
            m_rx_ovf = eng_rx_valid && mrx.size() == DEPTH;
            m_rx_unf = rx_pop && mrx.size() == 0;
            if (tpop)  void'(mtx.pop_front());
            if (tpush) mtx.push_back(tx_push_data);
            if (rpop)  void'(mrx.pop_front());
            if (rpush) mrx.push_back(eng_rx_data);
            if (cfg_we && int'(cfg_wdata) < DEPTH) mth[cfg_sel] = int'(cfg_wdata);
        end
    end

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic compare_all();
        int tl, rl;
        tl = mtx.size();
        rl = mrx.size();
        chk("R2 tx_level", int'(tx_level), tl);
        chk("R2 eng_tx_valid", int'(eng_tx_valid), int'(tl != 0));
        chk("R2 eng_tx_data", int'(eng_tx_data), tl != 0 ? int'(mtx[0]) : 0);
        chk("R4 rx_level", int'(rx_level), rl);
        chk("R4 rx_pop_data", int'(rx_pop_data), rl != 0 ? int'(mrx[0]) : 0);
        chk("R5 eng_rx_ready", int'(eng_rx_ready), int'(rl != DEPTH));
        chk("R8 tx_full", int'(tx_full), int'(tl == DEPTH));
        chk("R8 tx_empty", int'(tx_empty), int'(tl == 0));
        chk("R8 rx_full", int'(rx_full), int'(rl == DEPTH));
        chk("R8 rx_empty", int'(rx_empty), int'(rl == 0));
        chk("R3 tx_ovf", int'(tx_ovf), int'(m_tx_ovf));
        chk("R5 rx_ovf", int'(rx_ovf), int'(m_rx_ovf));
        chk("R6 rx_unf", int'(rx_unf), int'(m_rx_unf));
        chk("R7 tx_irq_th", int'(tx_irq_th), mth[0]);
        chk("R7 rx_irq_th", int'(rx_irq_th), mth[1]);
        chk("R7 tx_dma_th", int'(tx_dma_th), mth[2]);
        chk("R7 rx_dma_th", int'(rx_dma_th), mth[3]);
        chk("R9 irq_tx_low", int'(irq_tx_low), int'(tl <= mth[0]));
        chk("R9 irq_rx_high", int'(irq_rx_high), int'(rl > mth[1]));
        chk("R10 dma_tx_req", int'(dma_tx_req), int'(dma_en[1] && tl <= mth[2]));
        chk("R10 dma_rx_req", int'(dma_rx_req), int'(dma_en[0] && rl > mth[3]));
    endtask

    task automatic step();
        @(posedge clk);
        @(negedge clk);
        compare_all();
    endtask

    task automatic idle();
        tx_push = 0; rx_pop = 0; cfg_we = 0; eng_tx_ready = 0; eng_rx_valid = 0;
    endtask

    task automatic cfg(input int sel, input int val);
        idle();
        cfg_we = 1; cfg_sel = 2'(sel); cfg_wdata = TH_W'(val);
        step();
        idle();
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 0;
        @(negedge clk);
        // R1: state right after reset
        chk("R1 tx_level", int'(tx_level), 0);
        chk("R1 rx_empty", int'(rx_empty), 1);
        chk("R1 tx_empty", int'(tx_empty), 1);
        chk("R1 tx_full", int'(tx_full), 0);
        chk("R1 thresholds", int'(tx_irq_th | rx_irq_th | tx_dma_th | rx_dma_th), 0);
        chk("R1 dma", int'(dma_tx_req | dma_rx_req), 0);
        chk("R1 pulses", int'(tx_ovf | rx_ovf | rx_unf), 0);
        compare_all();

        // R7: accepted and refused threshold writes
        cfg(0, 3);  chk("R7 accept", int'(tx_irq_th), 3);
        cfg(1, 5);  cfg(2, 7);  cfg(3, 0);
        cfg(0, DEPTH);      chk("R7 refuse depth", int'(tx_irq_th), 3);
        cfg(0, 31);         chk("R7 refuse max", int'(tx_irq_th), 3);
        cfg(2, DEPTH - 1);  chk("R7 accept top", int'(tx_dma_th), DEPTH - 1);
        cfg(2, 7);
        dma_en = 2'b11;

        // R3: fill the transmit queue beyond its depth
        for (int i = 0; i < DEPTH + 2; i++) begin
            idle(); tx_push = 1; tx_push_data = DATA_W'(16'hA000 + i);
            step();
        end
        chk("R3 full level", int'(tx_level), DEPTH);
        // R3: push into full while engine pops: push still dropped
        idle(); tx_push = 1; tx_push_data = 16'hBEEF; eng_tx_ready = 1;
        step();
        chk("R3 drop with pop", int'(tx_level), DEPTH - 1);
        chk("R3 ovf pulse", int'(tx_ovf), 1);
        idle(); step();
        chk("R3 ovf one cycle", int'(tx_ovf), 0);
        // drain to 5
        while (tx_level > 5) begin idle(); eng_tx_ready = 1; step(); end
        // R11: simultaneous push and pop
        idle(); tx_push = 1; tx_push_data = 16'h1234; eng_tx_ready = 1;
        step();
        chk("R11 level kept", int'(tx_level), 5);
        while (tx_level != 0) begin idle(); eng_tx_ready = 1; step(); end
        chk("R2 empty data zero", int'(eng_tx_data), 0);

        // R5: overfill the receive queue
        for (int i = 0; i < DEPTH + 2; i++) begin
            idle(); eng_rx_valid = 1; eng_rx_data = DATA_W'(16'h5000 + 3 * i);
            step();
        end
        chk("R5 rx full", int'(rx_full), 1);
        chk("R4 head", int'(rx_pop_data), 16'h5000);
        while (rx_level != 0) begin idle(); rx_pop = 1; step(); end
        // R6: pop when empty
        idle(); rx_pop = 1; step();
        chk("R6 unf pulse", int'(rx_unf), 1);
        chk("R6 data zero", int'(rx_pop_data), 0);
        // R6: pop on empty while a frame arrives
        idle(); rx_pop = 1; eng_rx_valid = 1; eng_rx_data = 16'h7777; step();
        chk("R6 unf with arrival", int'(rx_unf), 1);
        chk("R4 arrival kept", int'(rx_level), 1);

        // mixed random traffic
        for (int n = 0; n < 3000; n++) begin
            idle();
            tx_push      = ($urandom % 2) == 0;
            tx_push_data = DATA_W'($urandom);
            eng_tx_ready = ($urandom % 5) < 2;
            eng_rx_valid = ($urandom % 2) == 0;
            eng_rx_data  = DATA_W'($urandom);
            rx_pop       = ($urandom % 5) < 2;
            cfg_we       = ($urandom % 10) == 0;
            cfg_sel      = 2'($urandom);
            cfg_wdata    = TH_W'($urandom);
            if (($urandom % 50) == 0) dma_en = 2'($urandom);
            step();
        end

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog expired");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule